// File: doc/BRIEF.md
# Five-Hot Bit Position List Encoder

This block turns a 16-bit vector carrying exactly five set bits into a 20-bit word of five 4-bit fields. Each field holds the index of one set bit. The word is meant to be consumed as a group, with all five positions handled side by side. Field order carries no meaning for a consumer, but this block fixes the order so that results can be compared exactly.

The vector is split into a low byte and a high byte. Each byte indexes its own 256-entry table, and those tables are computed at elaboration time. The low table packs the positions it finds into the lowest fields, counting upward from field 0. The high table packs its positions into the highest fields, counting downward from field 4. Both tables also return the popcount of their byte. A second stage picks each output field from one table or the other, using a 2:1 select driven by the low-byte popcount.

The block is a two-stage pipeline that accepts a new sample on every clock. A valid strobe travels alongside the data. An error flag, aligned with the output valid, marks any input whose total popcount differs from five.

Top module: `five_hot_index_encoder`

## Requirements
- R1: For any input with exactly five bits set, the five 4-bit fields of `out_list` are distinct, and together they name exactly the set bits of the input.
- R2: Input 16'hC007 produces `out_list` 20'hFE210: field 4 = 15, field 3 = 14, field 2 = 2, field 1 = 1, field 0 = 0.
- R3: Field order follows fixed rules. Let L be the number of set bits in bits 7:0. Fields 0 to L-1 hold the low-byte positions in ascending order. Fields 4 down to L hold the high-byte positions in descending order. Field k occupies `out_list[4k+3:4k]`.
- R4: `out_vld` equals `in_vld` from two clock edges earlier. `out_list` and `out_err` belong to the sample taken at that earlier edge. A new sample can be accepted on every cycle.
- R5: When `out_vld` is high, `out_err` is high exactly when the input popcount was not five. This covers inputs with 0 to 4 and 6 to 16 set bits.
- R6: `out_err` is low whenever `out_vld` is low.
- R7: A synchronous active-low reset clears `out_vld` and `out_err` at the next clock edge. Samples that were in flight when reset was applied never show up as valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input sample qualifier |
| in_vec | input | 16 | Five-hot input vector |
| out_vld | output | 1 | Result qualifier, two cycles after `in_vld` |
| out_list | output | 20 | Five 4-bit bit positions, field k at bits 4k+3:4k |
| out_err | output | 1 | Input popcount was not five |

## Verification
Each result appears two rising edges after its sample is taken. Samples are driven on the falling edge. Every falling edge is then checked against the sample driven two falling edges earlier, using a two-deep history kept in the bench that mirrors the stated latency. The sweep streams all 65536 input values back to back. A second pass with gaps in the valid strobe confirms that idle cycles give a low `out_vld` and `out_err` exactly two edges later. A reset applied mid-stream must suppress the samples that were in flight.

// File: rtl/fhe_pkg.sv
// Package: shared widths, types and the elaboration-time table builders
// for the five-hot position encoder. Assumes an even source width.
package fhe_pkg;

    localparam int unsigned SRC_W  = 16;
    localparam int unsigned HALF_W = SRC_W / 2;
    localparam int unsigned POS_W  = $clog2(SRC_W);
    localparam int unsigned SLOTS  = 5;
    localparam int unsigned CNT_W  = $clog2(HALF_W + 1);
    localparam int unsigned LIST_W = SLOTS * POS_W;
    localparam int unsigned DEPTH  = 1 << HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [LIST_W-1:0] list_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Low byte: positions ascending from field 0; extra bits beyond SLOTS dropped.
    function automatic list_t pack_low(input half_t b);
        list_t r;
        int    slot;
        r    = '0;
        slot = 0;
        for (int i = 0; i < int'(HALF_W); i++) begin
            if (b[i] && slot < int'(SLOTS)) begin
                r[slot*POS_W +: POS_W] = POS_W'(i);
                slot++;
            end
        end
        return r;
    endfunction

    // High byte: positions descending from the top field, offset by HALF_W.
    function automatic list_t pack_high(input half_t b);
        list_t r;
        int    slot;
        r    = '0;
        slot = int'(SLOTS) - 1;
        for (int i = int'(HALF_W) - 1; i >= 0; i--) begin
            if (b[i] && slot >= 0) begin
                r[slot*POS_W +: POS_W] = POS_W'(i + int'(HALF_W));
                slot--;
            end
        end
        return r;
    endfunction

    // Number of set bits in one half.
    function automatic cnt_t half_popcount(input half_t b);
        cnt_t c;
        c = '0;
        for (int i = 0; i < int'(HALF_W); i++) begin
            c = c + cnt_t'(b[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/fhe_half_table.sv
// Module: one half-width lookup table. UPPER selects the high-byte packing
// (descending from the top field) or the low-byte packing (ascending from
// field 0). Contents are computed at elaboration; the read is combinational.
module fhe_half_table
    import fhe_pkg::*;
#(
    parameter bit UPPER = 1'b0
) (
    input  half_t idx,
    output list_t list_o,
    output cnt_t  cnt_o
);

    typedef logic [DEPTH-1:0][LIST_W-1:0] list_tab_t;
    typedef logic [DEPTH-1:0][CNT_W-1:0]  cnt_tab_t;

    // Builds the packed-position table for the chosen half.
    function automatic list_tab_t build_lists(input bit upper);
        list_tab_t t;
        for (int a = 0; a < int'(DEPTH); a++) begin
            if (upper) t[a] = pack_high(half_t'(a));
            else       t[a] = pack_low(half_t'(a));
        end
        return t;
    endfunction

    // Builds the popcount table.
    function automatic cnt_tab_t build_counts();
        cnt_tab_t t;
        for (int a = 0; a < int'(DEPTH); a++) begin
            t[a] = half_popcount(half_t'(a));
        end
        return t;
    endfunction

    localparam list_tab_t LIST_TAB = build_lists(UPPER);
    localparam cnt_tab_t  CNT_TAB  = build_counts();

    // Table read.
    always_comb begin
        list_o = LIST_TAB[idx];
        cnt_o  = CNT_TAB[idx];
    end

endmodule

// File: rtl/fhe_lookup_stage.sv
// Module: pipeline stage 1. Looks up both halves of the input and registers
// the two packed lists, their popcounts and the valid bit. Only valid is reset.
module fhe_lookup_stage
    import fhe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [SRC_W-1:0]    vec_i,
    output logic                vld_q,
    output list_t               lo_list_q,
    output list_t               hi_list_q,
    output cnt_t                lo_cnt_q,
    output cnt_t                hi_cnt_q
);

    list_t lo_list, hi_list;
    cnt_t  lo_cnt,  hi_cnt;

    fhe_half_table #(.UPPER(1'b0)) i_lo_tab (
        .idx    (vec_i[HALF_W-1:0]),
        .list_o (lo_list),
        .cnt_o  (lo_cnt)
    );

    fhe_half_table #(.UPPER(1'b1)) i_hi_tab (
        .idx    (vec_i[SRC_W-1:HALF_W]),
        .list_o (hi_list),
        .cnt_o  (hi_cnt)
    );

    // Valid pipeline bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_i;
    end

    // Data registers, free running.
    always_ff @(posedge clk) begin
        lo_list_q <= lo_list;
        hi_list_q <= hi_list;
        lo_cnt_q  <= lo_cnt;
        hi_cnt_q  <= hi_cnt;
    end

endmodule

// File: rtl/fhe_merge_stage.sv
// Module: pipeline stage 2. Per field, a 2:1 select picks the low-table field
// when its index is below the low popcount, else the high-table field. Also
// flags a total popcount other than SLOTS. Valid and error are reset.
module fhe_merge_stage
    import fhe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vld_i,
    input  list_t lo_list_i,
    input  list_t hi_list_i,
    input  cnt_t  lo_cnt_i,
    input  cnt_t  hi_cnt_i,
    output logic  vld_q,
    output list_t list_q,
    output logic  err_q
);

    localparam int unsigned SUM_W = CNT_W + 1;

    list_t            merged;
    logic [SUM_W-1:0] total;

    // One select per field.
    for (genvar k = 0; k < int'(SLOTS); k++) begin : g_slot
        logic take_lo;
        // Field k comes from the low table while k is below the low count.
        always_comb begin
            take_lo = (32'(lo_cnt_i) > k);
            merged[k*POS_W +: POS_W] = take_lo ? lo_list_i[k*POS_W +: POS_W]
                                               : hi_list_i[k*POS_W +: POS_W];
        end
    end

    // Total popcount of the sample.
    always_comb total = SUM_W'(lo_cnt_i) + SUM_W'(hi_cnt_i);

    // Valid and error registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= vld_i;
            err_q <= vld_i && (total != SUM_W'(SLOTS));
        end
    end

    // Merged data register, free running.
    always_ff @(posedge clk) list_q <= merged;

endmodule

// File: rtl/five_hot_index_encoder.sv
// Module: top of the five-hot to position-list encoder. Two-stage pipeline,
// one sample per clock, result two edges after the sample. Assumes the
// consumer ignores out_list while out_vld is low or out_err is high.
module five_hot_index_encoder
    import fhe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [SRC_W-1:0]  in_vec,
    output logic              out_vld,
    output logic [LIST_W-1:0] out_list,
    output logic              out_err
);

    logic  s1_vld;
    list_t s1_lo_list, s1_hi_list;
    cnt_t  s1_lo_cnt,  s1_hi_cnt;

    fhe_lookup_stage i_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (in_vld),
        .vec_i     (in_vec),
        .vld_q     (s1_vld),
        .lo_list_q (s1_lo_list),
        .hi_list_q (s1_hi_list),
        .lo_cnt_q  (s1_lo_cnt),
        .hi_cnt_q  (s1_hi_cnt)
    );

    fhe_merge_stage i_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (s1_vld),
        .lo_list_i (s1_lo_list),
        .hi_list_i (s1_hi_list),
        .lo_cnt_i  (s1_lo_cnt),
        .hi_cnt_i  (s1_hi_cnt),
        .vld_q     (out_vld),
        .list_q    (out_list),
        .err_q     (out_err)
    );

endmodule

// File: rtl/fhe_checker.sv
// Module: property checker for the encoder, bound to the top module.
module fhe_checker
    import fhe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [SRC_W-1:0]  in_vec,
    input logic              out_vld,
    input logic [LIST_W-1:0] out_list,
    input logic              out_err
);

    logic [SRC_W-1:0] named_mask;

    // Mask of the positions named by the output fields.
    always_comb begin
        named_mask = '0;
        for (int k = 0; k < int'(SLOTS); k++) begin
            named_mask[out_list[k*POS_W +: POS_W]] = 1'b1;
        end
    end

    // R4
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##1 out_vld);

    // R4
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ##1 !out_vld);

    // R1
    set_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_err) |-> (named_mask == $past(in_vec, 2)));

    // R5
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_err == ($countones($past(in_vec, 2)) != SLOTS)));

    // R6
    err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_vld);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !out_err));

endmodule

bind five_hot_index_encoder fhe_checker i_fhe_checker (.*);

// File: tb/test_five_hot_index_encoder.sv
// Bench: exhaustive stream of all inputs plus gap and reset patterns.
module test_five_hot_index_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] in_vec = '0;
    logic        out_vld;
    logic [19:0] out_list;
    logic        out_err;

    int n_checks = 0;
    int n_errors = 0;

    logic        hv [2];
    logic [15:0] hd [2];

    five_hot_index_encoder i_five_hot_index_encoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_vec   (in_vec),
        .out_vld  (out_vld),
        .out_list (out_list),
        .out_err  (out_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected ordered word per R3: low bits ascending from field 0,
    // high bits descending from field 4.
    function automatic logic [19:0] model_word(input logic [15:0] d);
        logic [19:0] w;
        int lo_slot, hi_slot;
        w = '0;
        lo_slot = 0;
        hi_slot = 4;
        for (int i = 0; i < 8; i++)
            if (d[i]) begin w[lo_slot*4 +: 4] = 4'(i); lo_slot++; end
        for (int i = 15; i >= 8; i--)
            if (d[i]) begin w[hi_slot*4 +: 4] = 4'(i); hi_slot--; end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare outputs with the sample from two falling edges ago (R4).
    task automatic check_due();
        logic [15:0] named;
        if (hv[1]) begin
            check(out_vld == 1'b1, "R4 valid", 32'(out_vld), 1);
            if ($countones(hd[1]) == 5) begin
                check(out_err == 1'b0, "R5 no error", 32'(out_err), 0);
                check(out_list == model_word(hd[1]), "R3 order",
                      32'(out_list), 32'(model_word(hd[1])));
                named = '0;
                for (int k = 0; k < 5; k++) named[out_list[k*4 +: 4]] = 1'b1;
                check(named == hd[1], "R1 position set", 32'(named), 32'(hd[1]));
            end else begin
                check(out_err == 1'b1, "R5 error", 32'(out_err), 1);
            end
        end else begin
            check(out_vld == 1'b0, "R4 idle", 32'(out_vld), 0);
            check(out_err == 1'b0, "R6 error quiet", 32'(out_err), 0);
        end
    endtask

    // One falling-edge step: check, shift history, drive the next sample.
    task automatic step(input logic v, input logic [15:0] d);
        @(negedge clk);
        check_due();
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = v;     hd[0] = d;
        in_vld = v;
        in_vec = d;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        hv[0] = 0; hv[1] = 0; hd[0] = '0; hd[1] = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(out_vld == 1'b0 && out_err == 1'b0, "R7 reset state",
              {30'd0, out_vld, out_err}, 0);
        rst_n = 1'b1;

        // R2: the worked example
        step(1'b1, 16'hC007);
        step(1'b0, 16'h0000);
        @(negedge clk);
        check(out_vld && out_list == 20'hFE210, "R2 example", 32'(out_list), 32'hFE210);
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = 0;     hd[0] = '0;
        in_vld = 0;

        // R1 R3 R5: every input value, back to back
        for (int i = 0; i < 65536; i++) step(1'b1, 16'(i));

        // R4 R6: gaps in the valid strobe with five-hot and error inputs
        for (int i = 0; i < 600; i++)
            step(((i % 3) != 1), 16'((i * 16'h9E37) ^ 16'h001F));
        step(1'b0, '0);
        step(1'b0, '0);

        // R7: reset with samples in flight
        step(1'b1, 16'h8421 | 16'h0100);
        step(1'b1, 16'h00F0);
        @(negedge clk);
        rst_n = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0 && out_err == 1'b0, "R7 in-flight dropped",
              {30'd0, out_vld, out_err}, 0);
        @(negedge clk);
        check(out_vld == 1'b0 && out_err == 1'b0, "R7 held clear",
              {30'd0, out_vld, out_err}, 0);
        rst_n = 1'b1;
        hv[0] = 0; hv[1] = 0;
        step(1'b1, 16'h1F00);
        step(1'b0, '0);
        step(1'b0, '0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule